// File: doc/BRIEF.md
# Length-Checked Serial Command Slave

This block is the serial front end of a load-driver core. A host talks to it over a four-wire link with chip select active low, in clock mode 0. Each frame carries a 24-bit command word, least significant bit first. Bit 0 of the word picks one of two 24-bit control registers. The word reaches that register only when chip select rises after exactly 24 clock pulses. At the same time the block shifts out the status word chosen by that same bit 0. The core supplies the two status words.

When chip select falls, the data output is enabled and at once shows the summary fault bit, which is bit 0 of status word 0. The host can poll this bit without clocking a frame. A valid frame with bit 22 set sends a one-cycle clear strobe to the core, which empties both status words. Bit 23 of any word shifted out is forced to 1, so a line stuck at 0 or at 1 never looks like a real status reply.

All link inputs are oversampled by a fast system clock through two-flop synchronisers. The serial clock must therefore stay well below the system clock rate.

Top module: `ctl_frame_slave`

## Requirements
- R1: `sdo_oe_o` is 0 while chip select is high and 1 while it is low, two system clocks behind `cs_n_i`.
- R2: After chip select falls and before any serial clock edge, `sdo_o` equals `stat0_i[0]`.
- R3: Data in is sampled on serial clock rising edges, least significant bit first. After exactly 24 pulses, the chip-select rising edge writes the word to `ctrl0_o` when its bit 0 is 0, and to `ctrl1_o` when its bit 0 is 1.
- R4: A frame with fewer than 24 clock pulses leaves both control registers unchanged.
- R5: A frame with more than 24 clock pulses leaves both control registers unchanged.
- R6: `stat_clr_o` pulses high for exactly one system clock after the chip-select rising edge that ends a valid frame with bit 22 set. It stays low for invalid frames and for frames with bit 22 clear.
- R7: The first rising edge loads status word 1 if the received bit 0 is 1, otherwise status word 0. After the k-th falling edge (k = 1..23), `sdo_o` carries bit k of that word, and bit 23 always reads 1.
- R8: During and straight after reset, both control registers are 0, `stat_clr_o` is 0 and `sdo_oe_o` is 0.
- R9: Serial clock and data activity while chip select is high changes neither control register and produces no clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, mode 0 |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable of the tri-state data out pad |
| ctrl0_o | output | 24 | Control register 0 |
| ctrl1_o | output | 24 | Control register 1 |
| stat0_i | input | 24 | Status word 0 from the core |
| stat1_i | input | 24 | Status word 1 from the core |
| stat_clr_o | output | 1 | One-cycle strobe that clears both status words |

## Verification
The bench targets frame length at 23, 24, 25 and longer counts. A counter that is off by one, or that wraps instead of saturating, would commit short frames, or a long frame whose count had rolled over. Frames select register 1 and carry the reset bit, checking that the selector bit steers both the write and the returned word, and that the clear strobe appears only for valid frames. Each frame first reads the pre-clock fault preview. This catches a design that waits for a clock, or that previews the wrong status word. Random status words then check the forced link bit and that bit order is not reversed.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;
  localparam int FRAME_W  = 24;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam int SEL_BIT  = 0;
  localparam int CLR_BIT  = 22;
  localparam int LINK_BIT = 23;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  typedef logic [FRAME_W-1:0] word_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ctl_rx.sv
module ctl_rx
  import ctl_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_stb_i,
  input  logic             sdi_i,
  output word_t            word_o,
  output logic [CNT_W-1:0] cnt_o
);
  word_t            shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (bit_stb_i) begin
      shreg_d = {sdi_i, shreg_q[FRAME_W-1:1]};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign word_o = shreg_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ctl_tx.sv
module ctl_tx
  import ctl_frame_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  load_i,
  input  logic  shift_i,
  input  word_t word_i,
  input  logic  preview_i,
  output logic  sdo_o
);
  word_t tx_q, tx_d;
  logic  loaded_q, loaded_d;

  always_comb begin
    tx_d     = tx_q;
    loaded_d = loaded_q;
    if (start_i) begin
      loaded_d = 1'b0;
    end else if (load_i) begin
      tx_d     = word_i;
      loaded_d = 1'b1;
    end else if (shift_i && loaded_q) begin
      tx_d = {1'b0, tx_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      loaded_q <= 1'b0;
    end else begin
      tx_q     <= tx_d;
      loaded_q <= loaded_d;
    end
  end

  assign sdo_o = loaded_q ? tx_q[0] : preview_i;
endmodule

// File: rtl/ctl_frame_slave.sv
module ctl_frame_slave
  import ctl_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        sclk_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  output logic [23:0] ctrl0_o,
  output logic [23:0] ctrl1_o,
  input  logic [23:0] stat0_i,
  input  logic [23:0] stat1_i,
  output logic        stat_clr_o
);
  logic [2:0]       pins_s;
  logic             cs_s, sclk_s, sdi_s;
  logic             cs_q, sclk_q;
  logic             active, cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic             first_rise, commit;
  logic [CNT_W-1:0] bit_cnt;
  word_t            rx_word, stat_sel;
  word_t            ctrl0_q, ctrl0_d, ctrl1_q, ctrl1_d;
  logic             clr_q, clr_d;

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cs_n_i, sclk_i, sdi_i}),
    .q_o  (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  assign active     = ~cs_s;
  assign cs_fall    = cs_q & ~cs_s;
  assign cs_rise    = ~cs_q & cs_s;
  assign sclk_rise  = active & ~cs_fall & sclk_s & ~sclk_q;
  assign sclk_fall  = active & ~cs_fall & ~sclk_s & sclk_q;
  assign first_rise = sclk_rise & (bit_cnt == '0);
  assign commit     = cs_rise & (bit_cnt == CNT_FULL);

  ctl_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cs_fall),
    .bit_stb_i(sclk_rise),
    .sdi_i    (sdi_s),
    .word_o   (rx_word),
    .cnt_o    (bit_cnt)
  );

  always_comb begin
    stat_sel           = sdi_s ? stat1_i : stat0_i;
    stat_sel[LINK_BIT] = 1'b1;
  end

  ctl_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cs_fall),
    .load_i   (first_rise),
    .shift_i  (sclk_fall),
    .word_i   (stat_sel),
    .preview_i(stat0_i[0]),
    .sdo_o    (sdo_o)
  );

  always_comb begin
    ctrl0_d = ctrl0_q;
    ctrl1_d = ctrl1_q;
    clr_d   = 1'b0;
    if (commit) begin
      if (rx_word[SEL_BIT]) ctrl1_d = rx_word;
      else                  ctrl0_d = rx_word;
      clr_d = rx_word[CLR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= '0;
      ctrl1_q <= '0;
      clr_q   <= 1'b0;
    end else begin
      ctrl0_q <= ctrl0_d;
      ctrl1_q <= ctrl1_d;
      clr_q   <= clr_d;
    end
  end

  assign ctrl0_o    = ctrl0_q;
  assign ctrl1_o    = ctrl1_q;
  assign stat_clr_o = clr_q;
  assign sdo_oe_o   = active;
endmodule

// File: rtl/ctl_frame_slave_chk.sv
module ctl_frame_slave_chk
  import ctl_frame_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_i,
  input logic             sdo_oe_o,
  input logic [23:0]      ctrl0_o,
  input logic [23:0]      ctrl1_o,
  input logic             stat_clr_o,
  input logic             cs_rise,
  input logic [CNT_W-1:0] bit_cnt
);
  p_oe_follows_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o == !$past(cs_n_i, 2));

  p_ctrl0_only_on_full_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl0_o) |-> ($past(cs_rise) && $past(bit_cnt) == CNT_FULL));

  p_ctrl1_only_on_full_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl1_o) |-> ($past(cs_rise) && $past(bit_cnt) == CNT_FULL));

  p_count_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT);

  p_clr_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_o |=> !stat_clr_o);

  p_clr_needs_valid_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_o |-> ($past(cs_rise) && $past(bit_cnt) == CNT_FULL));
endmodule

bind ctl_frame_slave ctl_frame_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_i    (cs_n_i),
  .sdo_oe_o  (sdo_oe_o),
  .ctrl0_o   (ctrl0_o),
  .ctrl1_o   (ctrl1_o),
  .stat_clr_o(stat_clr_o),
  .cs_rise   (cs_rise),
  .bit_cnt   (bit_cnt)
);

// File: tb/ctl_frame_slave_tb.sv
module ctl_frame_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, sdi;
  logic        sdo, sdo_oe, stat_clr;
  logic [23:0] ctrl0, ctrl1, stat0, stat1;

  int checks = 0;
  int errors = 0;
  int clr_cnt = 0;
  logic [23:0] exp0 = '0;
  logic [23:0] exp1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_frame_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1),
    .stat0_i(stat0), .stat1_i(stat1), .stat_clr_o(stat_clr)
  );

  always @(posedge clk) if (stat_clr === 1'b1) clr_cnt <= clr_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] reply(input logic [23:0] w, input logic [23:0] s0, input logic [23:0] s1);
    logic [23:0] b;
    b = w[0] ? s1 : s0;
    return {1'b1, b[22:1], s0[0]};
  endfunction

  task automatic run_frame(input logic [23:0] w, input int n);
    logic [23:0] got, s0, s1;
    int c0;
    got = '0;
    s0 = $urandom; s1 = $urandom;
    @(negedge clk);
    stat0 = s0; stat1 = s1; c0 = clr_cnt;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b1, "R1 oe low-cs", {23'b0, sdo_oe}, 24'd1);
    chk(sdo == s0[0], "R2 preview", {23'b0, sdo}, {23'b0, s0[0]});
    for (int i = 0; i < n; i++) begin
      sdi = (i < 24) ? w[i] : 1'($urandom);
      repeat (HALF_SCK) @(negedge clk);
      if (i < 24) got[i] = sdo;
      sclk = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF_SCK) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF_SCK) @(negedge clk);
    chk(sdo_oe == 1'b0, "R1 oe high-cs", {23'b0, sdo_oe}, 24'd0);
    if (n >= 24)
      chk(got == reply(w, s0, s1), "R7 reply", got, reply(w, s0, s1));
    if (n == 24) begin
      if (w[0]) exp1 = w; else exp0 = w;
    end
    chk(ctrl0 == exp0, n == 24 ? "R3 ctrl0" : (n < 24 ? "R4 ctrl0" : "R5 ctrl0"), ctrl0, exp0);
    chk(ctrl1 == exp1, n == 24 ? "R3 ctrl1" : (n < 24 ? "R4 ctrl1" : "R5 ctrl1"), ctrl1, exp1);
    chk((clr_cnt - c0) == ((n == 24 && w[22]) ? 1 : 0), "R6 clear strobe",
        24'(clr_cnt - c0), (n == 24 && w[22]) ? 24'd1 : 24'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; stat0 = '0; stat1 = '0;
    repeat (4) @(negedge clk);
    chk(ctrl0 == 24'd0 && ctrl1 == 24'd0, "R8 ctrl reset", ctrl0 | ctrl1, 24'd0);
    chk(stat_clr == 1'b0 && sdo_oe == 1'b0, "R8 outputs reset", {22'b0, stat_clr, sdo_oe}, 24'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ctrl0 == 24'd0 && ctrl1 == 24'd0 && sdo_oe == 1'b0, "R8 after release", ctrl0 | ctrl1, 24'd0);

    // directed corner cases
    run_frame(24'h2A5A5A, 24);          // register 0
    run_frame(24'h1234C7, 24);          // register 1
    run_frame(24'h0FFFF0, 23);          // one short (R4)
    run_frame(24'h0FFFF1, 25);          // one long (R5)
    run_frame(24'h7EEEEE, 40);          // long frame, saturating count (R5)
    run_frame(24'h400000, 24);          // reset bit, register 0 (R6)
    run_frame(24'h400001, 23);          // reset bit on short frame: no strobe (R6)
    run_frame(24'hC00001, 24);          // reset bit, register 1 (R6)
    run_frame(24'h000000, 1);           // single clock
    run_frame(24'hFFFFFF, 24);

    // R9: activity while chip select is high
    begin
      int c0;
      logic [23:0] k0, k1;
      c0 = clr_cnt; k0 = ctrl0; k1 = ctrl1;
      for (int i = 0; i < 30; i++) begin
        sdi = 1'($urandom);
        repeat (HALF_SCK) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF_SCK) @(negedge clk);
        sclk = 1'b0;
      end
      repeat (HALF_SCK) @(negedge clk);
      chk(ctrl0 == k0, "R9 ctrl0 untouched", ctrl0, k0);
      chk(ctrl1 == k1, "R9 ctrl1 untouched", ctrl1, k1);
      chk(clr_cnt == c0 && sdo_oe == 1'b0, "R9 no strobe", 24'(clr_cnt - c0), 24'd0);
    end

    // constrained random frames
    for (int f = 0; f < 30; f++) begin
      int sel, n;
      sel = $urandom_range(0, 3);
      n = (sel == 0) ? $urandom_range(1, 23) : (sel == 1) ? $urandom_range(25, 32) : 24;
      run_frame(24'($urandom), n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule